// File: doc/BRIEF.md
# Trap Return State Restorer

This block returns a processor from a trap handler. It holds a small stack of saved trap contexts, one per trap level. Each context is a saved PC, a saved next-PC, a packed 64-bit trap state word and a saved hypervisor state. A trap-entry push stores a context one level up and raises the trap level. A return command then unpacks the context at the current level into the architectural registers and drops the trap level by one. The two return flavours are "done" and "retry". "Done" skips the trapped instruction. "Retry" re-executes it.

The restore is run by a three-state controller: `IDLE`, `APPLY` and `SIGNAL`. From `IDLE`, a command at a non-zero trap level takes the *accept* transition to `APPLY`. A command at trap level zero takes the *reject* transition, which stays in `IDLE` and raises a one-cycle error. `APPLY` writes every restored field, lowers the trap level and takes the *commit* transition to `SIGNAL`. `SIGNAL` drives a one-cycle interrupt-recheck strobe for downstream logic and takes the *finish* transition back to `IDLE`.

The window count, stack depth, PC width, hypervisor-state width and hypervisor support are all parameters. With hypervisor support off, the global level and hypervisor state stay zero.

Top module: `trap_return_unit`

## Requirements
- R1: After reset the trap level, the PC, the next-PC, the condition codes, the address space, the processor state, the window pointer, the global level, the hypervisor state, `busy`, `err_pulse` and `irq_recheck` are all zero.
- R2: In `IDLE`, a `push_vld` with no `cmd_vld` in the same cycle stores the pushed context at level tl+1 and raises tl by one. The push is ignored when tl already equals MAXTL, and also when `cmd_vld` is high in the same cycle.
- R3: A done command (`cmd_retry`=0) sets the PC to the saved next-PC and the next-PC to the saved next-PC plus 4, wrapping at the PC width.
- R4: A retry command (`cmd_retry`=1) sets the PC to the saved PC and the next-PC to the saved next-PC.
- R5: The condition code output is trap state bits 39:32, with the 64-bit codes in the upper nibble and the 32-bit codes in the lower nibble. The address space output is bits 31:24.
- R6: The processor state output is trap state bits 19:8 ANDed with 12'hF3F, so bits 7:6 are always zero.
- R7: The window pointer output is NWIN-1 minus (trap state bits 7:0 modulo NWIN).
- R8: With HV_EN=1, the global level is trap state bits 42:40 and the hypervisor state is the saved copy at the level being left. With HV_EN=0, both stay zero.
- R9: Each return lowers tl by exactly one. The entries below it are kept, so nested returns restore successive contexts.
- R10: A command at tl=0 pulses `err_pulse` for one cycle, starting one clock after it is sampled. It changes no output and gives no recheck strobe.
- R11: An accepted command raises `busy` for two cycles. The restored values and the new tl appear after the second edge, and `irq_recheck` is high exactly during the cycle after that edge. Commands and pushes seen while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Return command request |
| cmd_retry | input | 1 | 1 = retry, 0 = done |
| push_vld | input | 1 | Trap-entry push request |
| push_pc | input | PCW | Saved PC to push |
| push_npc | input | PCW | Saved next-PC to push |
| push_tstate | input | 64 | Packed trap state word to push |
| push_hpstate | input | HPW | Saved hypervisor state to push |
| busy | output | 1 | Restore in progress |
| pc | output | PCW | Restored PC |
| npc | output | PCW | Restored next-PC |
| ccr | output | 8 | Restored condition codes |
| asi | output | 8 | Restored address space identifier |
| pstate | output | 12 | Restored processor state |
| cwp | output | CWW | Restored window pointer, reversed form |
| gl | output | 3 | Restored global level |
| hpstate | output | HPW | Restored hypervisor state |
| tl | output | TLW | Current trap level |
| err_pulse | output | 1 | Return attempted at trap level zero |
| irq_recheck | output | 1 | Re-evaluate pending interrupts |

## Verification
The bench builds two copies with NWIN=5 and MAXTL=3. One copy has HV_EN=1 and the other HV_EN=0, and both get the same stimulus. With a window count that is not a power of two, the modulo reduction is exercised on raw values of 4, 13 and 255. A depth of three lets the stack fill and the overflow push be tested within a few operations. The HV_EN=0 copy shows that the global level and hypervisor state stay zero while the other fields still restore.

// File: rtl/trs_pkg.sv
package trs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_SIGNAL = 2'd2
    } trs_state_e;

    localparam logic [11:0] PSTATE_KEEP = 12'hF3F;
    localparam int TS_W      = 64;
    localparam int CCR_LSB   = 32;
    localparam int ASI_LSB   = 24;
    localparam int PST_LSB   = 8;
    localparam int GL_LSB    = 40;
endpackage

// File: rtl/trs_stack.sv
module trs_stack #(
    parameter int MAXTL = 5,
    parameter int PCW   = 64,
    parameter int HPW   = 8,
    localparam int TLW  = $clog2(MAXTL + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [TLW-1:0]          wr_lvl,
    input  logic [PCW-1:0]          wr_pc,
    input  logic [PCW-1:0]          wr_npc,
    input  logic [trs_pkg::TS_W-1:0] wr_ts,
    input  logic [HPW-1:0]          wr_hp,
    input  logic [TLW-1:0]          rd_lvl,
    output logic [PCW-1:0]          rd_pc,
    output logic [PCW-1:0]          rd_npc,
    output logic [trs_pkg::TS_W-1:0] rd_ts,
    output logic [HPW-1:0]          rd_hp
);
    logic [PCW-1:0]           pc_mem  [MAXTL+1];
    logic [PCW-1:0]           npc_mem [MAXTL+1];
    logic [trs_pkg::TS_W-1:0] ts_mem  [MAXTL+1];
    logic [HPW-1:0]           hp_mem  [MAXTL+1];

    always_ff @(posedge clk) begin
        for (int i = 0; i <= MAXTL; i++) begin
            if (!rst_n) begin
                pc_mem[i]  <= '0;
                npc_mem[i] <= '0;
                ts_mem[i]  <= '0;
                hp_mem[i]  <= '0;
            end else if (wr_en && (int'(wr_lvl) == i)) begin
                pc_mem[i]  <= wr_pc;
                npc_mem[i] <= wr_npc;
                ts_mem[i]  <= wr_ts;
                hp_mem[i]  <= wr_hp;
            end
        end
    end

    assign rd_pc  = pc_mem[rd_lvl];
    assign rd_npc = npc_mem[rd_lvl];
    assign rd_ts  = ts_mem[rd_lvl];
    assign rd_hp  = hp_mem[rd_lvl];
endmodule

// File: rtl/trs_unpack.sv
module trs_unpack #(
    parameter int NWIN = 8,
    localparam int CWW = $clog2(NWIN)
) (
    input  logic [trs_pkg::TS_W-1:0] ts,
    output logic [7:0]               ccr_f,
    output logic [7:0]               asi_f,
    output logic [11:0]              pst_f,
    output logic [CWW-1:0]           cwp_f,
    output logic [2:0]               gl_f
);
    import trs_pkg::*;

    logic [7:0]     raw_win;
    logic [CWW-1:0] wrapped;
    wire unused_ts_bits = ^{ts[TS_W-1:GL_LSB+3], ts[PST_LSB+15:PST_LSB+12]};

    assign raw_win = ts[7:0];
    assign wrapped = CWW'(int'(raw_win) % NWIN);

    always_comb begin
        ccr_f = ts[CCR_LSB +: 8];
        asi_f = ts[ASI_LSB +: 8];
        pst_f = ts[PST_LSB +: 12] & PSTATE_KEEP;
        cwp_f = CWW'(NWIN - 1) - wrapped;
        gl_f  = ts[GL_LSB +: 3];
    end

    always_comb begin
        a_r7_wrap_in_range: assert (int'(wrapped) < NWIN);
    end
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_vld,
    input  logic tl_zero,
    output logic accept,
    output logic apply_en,
    output logic busy,
    output logic recheck,
    output logic err
);
    import trs_pkg::*;

    trs_state_e state_q, state_d;
    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_IDLE) && cmd_vld && tl_zero;
        end
    end

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        apply_en = 1'b0;
        recheck  = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (cmd_vld && !tl_zero) begin
                    accept  = 1'b1;
                    state_d = ST_APPLY;
                end
            end
            ST_APPLY: begin
                apply_en = 1'b1;
                state_d  = ST_SIGNAL;
            end
            ST_SIGNAL: begin
                recheck = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign err = err_q;

    a_r11_apply_then_signal: assert property (@(posedge clk) disable iff (!rst_n)
        apply_en |=> recheck);
    a_r10_err_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
    parameter int NWIN  = 8,
    parameter int MAXTL = 5,
    parameter int PCW   = 64,
    parameter int HPW   = 8,
    parameter bit HV_EN = 1'b1,
    localparam int TLW  = $clog2(MAXTL + 1),
    localparam int CWW  = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_vld,
    input  logic           cmd_retry,
    input  logic           push_vld,
    input  logic [PCW-1:0] push_pc,
    input  logic [PCW-1:0] push_npc,
    input  logic [63:0]    push_tstate,
    input  logic [HPW-1:0] push_hpstate,
    output logic           busy,
    output logic [PCW-1:0] pc,
    output logic [PCW-1:0] npc,
    output logic [7:0]     ccr,
    output logic [7:0]     asi,
    output logic [11:0]    pstate,
    output logic [CWW-1:0] cwp,
    output logic [2:0]     gl,
    output logic [HPW-1:0] hpstate,
    output logic [TLW-1:0] tl,
    output logic           err_pulse,
    output logic           irq_recheck
);
    logic [TLW-1:0] tl_q;
    logic           accept, apply_en, push_en, retry_q;
    logic [PCW-1:0] rd_pc, rd_npc;
    logic [63:0]    rd_ts;
    logic [HPW-1:0] rd_hp;
    logic [7:0]     ccr_f, asi_f;
    logic [11:0]    pst_f;
    logic [CWW-1:0] cwp_f;
    logic [2:0]     gl_f;
    logic [PCW-1:0] pc_q, npc_q;
    logic [7:0]     ccr_q, asi_q;
    logic [11:0]    pst_q;
    logic [CWW-1:0] cwp_q;
    logic [2:0]     gl_q;
    logic [HPW-1:0] hp_q;

    trs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_vld  (cmd_vld),
        .tl_zero  (tl_q == '0),
        .accept   (accept),
        .apply_en (apply_en),
        .busy     (busy),
        .recheck  (irq_recheck),
        .err      (err_pulse)
    );

    assign push_en = push_vld && !cmd_vld && !busy && (int'(tl_q) < MAXTL);

    trs_stack #(.MAXTL(MAXTL), .PCW(PCW), .HPW(HPW)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (push_en),
        .wr_lvl (tl_q + 1'b1),
        .wr_pc  (push_pc),
        .wr_npc (push_npc),
        .wr_ts  (push_tstate),
        .wr_hp  (push_hpstate),
        .rd_lvl (tl_q),
        .rd_pc  (rd_pc),
        .rd_npc (rd_npc),
        .rd_ts  (rd_ts),
        .rd_hp  (rd_hp)
    );

    trs_unpack #(.NWIN(NWIN)) u_unpack (
        .ts    (rd_ts),
        .ccr_f (ccr_f),
        .asi_f (asi_f),
        .pst_f (pst_f),
        .cwp_f (cwp_f),
        .gl_f  (gl_f)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q    <= '0;
            retry_q <= 1'b0;
            pc_q    <= '0;
            npc_q   <= '0;
            ccr_q   <= '0;
            asi_q   <= '0;
            pst_q   <= '0;
            cwp_q   <= '0;
        end else begin
            if (accept) retry_q <= cmd_retry;
            if (push_en) tl_q <= tl_q + 1'b1;
            if (apply_en) begin
                tl_q  <= tl_q - 1'b1;
                pc_q  <= retry_q ? rd_pc : rd_npc;
                npc_q <= retry_q ? rd_npc : rd_npc + PCW'(4);
                ccr_q <= ccr_f;
                asi_q <= asi_f;
                pst_q <= pst_f;
                cwp_q <= cwp_f;
            end
        end
    end

    generate
        if (HV_EN) begin : g_hv
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    gl_q <= '0;
                    hp_q <= '0;
                end else if (apply_en) begin
                    gl_q <= gl_f;
                    hp_q <= rd_hp;
                end
            end
        end else begin : g_nohv
            assign gl_q = '0;
            assign hp_q = '0;
            wire unused_hv_src = ^{gl_f, rd_hp};
        end
    endgenerate

    assign pc      = pc_q;
    assign npc     = npc_q;
    assign ccr     = ccr_q;
    assign asi     = asi_q;
    assign pstate  = pst_q;
    assign cwp     = cwp_q;
    assign gl      = gl_q;
    assign hpstate = hp_q;
    assign tl      = tl_q;

    a_r9_tl_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        apply_en |=> (tl_q == TLW'(int'($past(tl_q)) - 1)));
    a_r2_tl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tl_q) <= MAXTL);
    a_r6_pstate_masked: assert property (@(posedge clk) disable iff (!rst_n)
        pst_q[7:6] == 2'b00);
    a_r7_cwp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cwp_q) < NWIN);
    a_r10_reject_keeps_tl: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (tl_q == '0) && !irq_recheck);
    a_r11_busy_ignores_push: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !apply_en) |=> $stable(tl_q));
endmodule

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
    localparam int NW = 5, MT = 3, PW = 64, HW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_vld = 0, cmd_retry = 0, push_vld = 0;
    logic [PW-1:0] push_pc = '0, push_npc = '0;
    logic [63:0] push_tstate = '0;
    logic [HW-1:0] push_hpstate = '0;

    logic busy, err_pulse, irq_recheck, busy_n, err_n, rck_n;
    logic [PW-1:0] pc, npc, pc_n, npc_n;
    logic [7:0] ccr, asi, ccr_n, asi_n;
    logic [11:0] pstate, pstate_n;
    logic [2:0] cwp, cwp_n, gl, gl_n;
    logic [HW-1:0] hpstate, hpstate_n;
    logic [1:0] tl, tl_n;

    int checks = 0, fails = 0;
    logic [PW-1:0] s_pc [4], s_npc [4];
    logic [63:0] s_ts [4];
    logic [HW-1:0] s_hp [4];
    int exp_tl = 0;

    always #2.5 clk = ~clk;

    trap_return_unit #(.NWIN(NW), .MAXTL(MT), .PCW(PW), .HPW(HW), .HV_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_retry(cmd_retry),
        .push_vld(push_vld), .push_pc(push_pc), .push_npc(push_npc),
        .push_tstate(push_tstate), .push_hpstate(push_hpstate),
        .busy(busy), .pc(pc), .npc(npc), .ccr(ccr), .asi(asi), .pstate(pstate),
        .cwp(cwp), .gl(gl), .hpstate(hpstate), .tl(tl),
        .err_pulse(err_pulse), .irq_recheck(irq_recheck));

    trap_return_unit #(.NWIN(NW), .MAXTL(MT), .PCW(PW), .HPW(HW), .HV_EN(1'b0)) uut_nohv (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_retry(cmd_retry),
        .push_vld(push_vld), .push_pc(push_pc), .push_npc(push_npc),
        .push_tstate(push_tstate), .push_hpstate(push_hpstate),
        .busy(busy_n), .pc(pc_n), .npc(npc_n), .ccr(ccr_n), .asi(asi_n), .pstate(pstate_n),
        .cwp(cwp_n), .gl(gl_n), .hpstate(hpstate_n), .tl(tl_n),
        .err_pulse(err_n), .irq_recheck(rck_n));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ts(input logic [2:0] g, input logic [7:0] c,
                                          input logic [7:0] a, input logic [11:0] p,
                                          input logic [7:0] w, input logic [20:0] junk);
        return {junk, g, c, a, 4'hF, p, w};
    endfunction

    task automatic t_reset();
        chk("R1 tl", 64'(tl), 0);
        chk("R1 pc", pc, 0);
        chk("R1 npc", npc, 0);
        chk("R1 fields", {ccr, asi, pstate, cwp, gl, hpstate}, 0);
        chk("R1 strobes", {busy, err_pulse, irq_recheck}, 0);
    endtask

    task automatic t_push(input logic [PW-1:0] p, input logic [PW-1:0] n,
                          input logic [63:0] ts, input logic [HW-1:0] h);
        @(negedge clk);
        push_vld = 1; push_pc = p; push_npc = n; push_tstate = ts; push_hpstate = h;
        @(posedge clk);
        @(negedge clk);
        push_vld = 0;
        if (exp_tl < MT) begin
            exp_tl++;
            s_pc[exp_tl] = p; s_npc[exp_tl] = n; s_ts[exp_tl] = ts; s_hp[exp_tl] = h;
        end
        chk("R2 tl after push", 64'(tl), 64'(exp_tl));
        chk("R2 tl after push nohv", 64'(tl_n), 64'(exp_tl));
    endtask

    task automatic t_return(input bit retry, input bit poke_busy);
        int lv = exp_tl;
        logic [PW-1:0] epc, enpc;
        @(negedge clk);
        cmd_vld = 1; cmd_retry = retry;
        @(posedge clk);
        @(negedge clk);
        chk("R11 busy in apply", 64'(busy), 1);
        if (poke_busy) begin
            push_vld = 1; push_pc = 64'hDEAD; push_tstate = '1;
        end else cmd_vld = 0;
        @(posedge clk);
        @(negedge clk);
        cmd_vld = 0; push_vld = 0;
        exp_tl = lv - 1;
        epc  = retry ? s_pc[lv] : s_npc[lv];
        enpc = retry ? s_npc[lv] : s_npc[lv] + 64'd4;
        chk(retry ? "R4 pc" : "R3 pc", pc, epc);
        chk(retry ? "R4 npc" : "R3 npc", npc, enpc);
        chk("R5 ccr", 64'(ccr), 64'(s_ts[lv][39:32]));
        chk("R5 asi", 64'(asi), 64'(s_ts[lv][31:24]));
        chk("R6 pstate", 64'(pstate), 64'(s_ts[lv][19:8] & 12'hF3F));
        chk("R7 cwp", 64'(cwp), 64'(NW - 1 - (int'(s_ts[lv][7:0]) % NW)));
        chk("R8 gl", 64'(gl), 64'(s_ts[lv][42:40]));
        chk("R8 hpstate", 64'(hpstate), 64'(s_hp[lv]));
        chk("R8 nohv gl/hp zero", {gl_n, hpstate_n}, 0);
        chk("R8 nohv pc", pc_n, epc);
        chk("R9 tl", 64'(tl), 64'(exp_tl));
        chk("R11 recheck", 64'(irq_recheck), 1);
        chk("R11 no err", 64'(err_pulse), 0);
        @(negedge clk);
        chk("R11 recheck one cycle", 64'(irq_recheck), 0);
        chk("R11 idle", 64'(busy), 0);
        if (poke_busy) chk("R11 busy push ignored", 64'(tl), 64'(exp_tl));
    endtask

    task automatic t_reject();
        logic [PW-1:0] opc = pc;
        logic [11:0] ops = pstate;
        @(negedge clk);
        cmd_vld = 1; cmd_retry = 0;
        @(posedge clk);
        @(negedge clk);
        cmd_vld = 0;
        chk("R10 err pulse", 64'(err_pulse), 1);
        chk("R10 no busy", 64'(busy), 0);
        chk("R10 tl", 64'(tl), 0);
        chk("R10 pc held", pc, opc);
        chk("R10 pstate held", 64'(pstate), 64'(ops));
        @(negedge clk);
        chk("R10 err one cycle", 64'(err_pulse), 0);
        chk("R10 no recheck", 64'(irq_recheck), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1;
                t_reset();
                t_reject();
                t_push(64'h1000, 64'h1004, mk_ts(3'd5, 8'hA5, 8'h80, 12'hFFF, 8'd255, 21'h0), 8'h11);
                t_push(64'h2000_0000_0000_0040, 64'h2000_0000_0000_0044,
                       mk_ts(3'd2, 8'h3C, 8'h14, 12'h0C0, 8'd13, 21'h1FFFFF), 8'h22);
                t_push(64'h300, 64'hFFFF_FFFF_FFFF_FFFC,
                       mk_ts(3'd7, 8'h0F, 8'hFF, 12'h123, 8'd4, 21'h0AAAA), 8'h33);
                t_push(64'h400, 64'h404, mk_ts(3'd1, 8'h01, 8'h01, 12'h001, 8'd1, 21'h0), 8'h44);
                t_return(1'b0, 1'b1);
                t_return(1'b1, 1'b0);
                t_return(1'b0, 1'b0);
                t_reject();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule